// File: doc/BRIEF.md
# Opcode-Driven Command/Response Framer

This block is the byte-level protocol engine of a power-management controller. A host pushes bytes in over a valid/ready handshake. The first byte of each transaction is an opcode. A lookup on the opcode tells the engine how many argument bytes follow. Some opcodes have a fixed count. Others are "variable": the byte right after the opcode carries the count. The arguments land in a command buffer. The engine then raises a request to a handler, which can read the buffer through a read port.

The handler writes its reply into a response buffer through a write port and signals completion. The engine then streams the reply back to the host over a second valid/ready handshake. The response shape also comes from the opcode lookup. A fixed-count response sends exactly that many bytes. A variable response sends a length byte first, and the handler supplies the length.

The engine has three protocol states: idle, receiving and responding. A synchronous abort returns it to idle from any of them. Lengths that exceed the buffer are clamped, and a sticky error flag is raised.

Top module: `cmd_framer`

## Requirements
- R1: After reset, `inReady` is 1, `outValid` is 0, `hndReq` is 0 and `lenErr` is 0.
- R2: For a fixed-argument opcode with count N>0, the engine accepts exactly N bytes after the opcode, storing byte k at buffer address k. In the cycle after the Nth byte is accepted, `hndReq` is 1, `hndOpcode` is the opcode and `hndArgCount` is N. `inReady` stays 0 while `hndReq` is 1.
- R3: For an opcode with a fixed argument count of zero, `hndReq` is 1 in the cycle right after the opcode byte is accepted.
- R4: For a variable-argument opcode, the byte after the opcode is a length L, and L argument bytes follow. If L is 0, `hndReq` rises in the cycle after the length byte.
- R5: A received length byte above BUF_DEPTH is treated as BUF_DEPTH. The same holds for a variable `hndRspLen` above BUF_DEPTH. Either case sets `lenErr`, which stays 1 until reset; abort does not clear it.
- R6: After `hndDone` for a fixed-response opcode with count N, the engine presents response buffer bytes 0..N-1 in order with no length byte. `outData` holds steady while `outValid` is 1 and `outReady` is 0.
- R7: After `hndDone` for a variable-response opcode, the engine first presents a length byte equal to min(`hndRspLen`, BUF_DEPTH), then that many response buffer bytes. If the length is 0, only the length byte is sent.
- R8: For a response count of zero, `inReady` is 1 and `outValid` is 0 in the cycle after `hndDone`.
- R9: After the last response byte is accepted, the engine is idle. The next transaction again reads and writes from buffer address 0.
- R10: `abort` sampled high forces idle on the next cycle from any state: `inReady` 1, `outValid` 0, `hndReq` 0. Any partial command is dropped.
- R11: Opcode shapes (args, response; "var" = length-prefixed):
  - 0x10, 0x11 and 0x70: (1, 0).
  - 0x20: (var, 0).
  - 0x21: (0, 0).
  - 0x30: (4, 0).
  - 0x31: (20, 0).
  - 0x38: (0, 4).
  - 0x39: (0, 20).
  - 0x48: (0, 1).
  - 0x78: (0, var).
  - Any other opcode takes variable arguments. Its response is variable when opcode bit 3 is 1 and empty when bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| abort | input | 1 | Synchronous return to idle |
| inValid | input | 1 | Host byte valid |
| inData | input | 8 | Host byte (opcode, length or argument) |
| inReady | output | 1 | Engine can take a host byte |
| outValid | output | 1 | Response byte valid |
| outData | output | 8 | Response byte (length or data) |
| outReady | input | 1 | Host takes the response byte |
| hndReq | output | 1 | Command complete, handler requested |
| hndOpcode | output | 8 | Opcode of the pending command |
| hndArgCount | output | CNT_W | Number of argument bytes stored |
| hndArgAddr | input | ADDR_W | Command buffer read address |
| hndArgData | output | 8 | Command buffer read data (combinational) |
| hndRspWe | input | 1 | Response buffer write enable |
| hndRspAddr | input | ADDR_W | Response buffer write address |
| hndRspData | input | 8 | Response buffer write data |
| hndRspLen | input | 8 | Response length for variable-response opcodes |
| hndDone | input | 1 | Handler finished; response buffer ready |
| lenErr | output | 1 | Sticky length-overflow flag |

## Verification
The bench builds the engine with BUF_DEPTH set to 32 rather than 128. This keeps the fixed 20-byte opcodes inside the buffer, while a length byte of 40 or a handler length of 50 both exceed it. The clamp and the sticky flag are therefore exercised in both directions, and full-buffer transfers stay short. Aborts are issued in the middle of argument collection, while the handler is pending and during a response stream. Each abort is followed by a complete transaction that must start again from address 0.

// File: rtl/cmd_framer_pkg.sv
package cmd_framer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_RESP = 2'd2
  } protoState_t;

  typedef enum logic [1:0] {
    PH_LEN  = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_t;

  // one direction of an opcode's framing: length-prefixed or a fixed count
  typedef struct packed {
    logic       isVar;
    logic [7:0] cnt;
  } dirShape_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic takeOp;
    logic takeArgLen;
    logic storeArg;
    logic takeRspLen;
    logic sendByte;
    logic clearPos;
    logic selLen;
  } dpStrobe_t;

  function automatic dirShape_t argShape(input logic [7:0] op);
    dirShape_t s;
    s.isVar = 1'b1;
    s.cnt   = 8'd0;
    case (op)
      8'h10, 8'h11, 8'h70: begin s.isVar = 1'b0; s.cnt = 8'd1;  end
      8'h21:               begin s.isVar = 1'b0; s.cnt = 8'd0;  end
      8'h30:               begin s.isVar = 1'b0; s.cnt = 8'd4;  end
      8'h31:               begin s.isVar = 1'b0; s.cnt = 8'd20; end
      8'h38, 8'h39, 8'h48, 8'h78:
                           begin s.isVar = 1'b0; s.cnt = 8'd0;  end
      default: ;
    endcase
    return s;
  endfunction

  function automatic dirShape_t rspShape(input logic [7:0] op);
    dirShape_t s;
    s.isVar = op[3];
    s.cnt   = 8'd0;
    case (op)
      8'h10, 8'h11, 8'h70, 8'h20, 8'h21, 8'h30, 8'h31:
                   begin s.isVar = 1'b0; s.cnt = 8'd0;  end
      8'h38:       begin s.isVar = 1'b0; s.cnt = 8'd4;  end
      8'h39:       begin s.isVar = 1'b0; s.cnt = 8'd20; end
      8'h48:       begin s.isVar = 1'b0; s.cnt = 8'd1;  end
      8'h78:       begin s.isVar = 1'b1; s.cnt = 8'd0;  end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cmd_framer_dp.sv
module cmd_framer_dp
  import cmd_framer_pkg::*;
#(
  parameter int BUF_DEPTH = 128,
  parameter int CNT_W     = $clog2(BUF_DEPTH + 1),
  parameter int ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        inData,
  input  logic [ADDR_W-1:0] hndArgAddr,
  output logic [7:0]        hndArgData,
  input  logic              hndRspWe,
  input  logic [ADDR_W-1:0] hndRspAddr,
  input  logic [7:0]        hndRspData,
  input  logic [7:0]        hndRspLen,
  output logic [7:0]        opcode,
  output logic [CNT_W-1:0]  argTarget,
  output logic              inArgVar,
  output logic              inArgZero,
  output logic              lenByteZero,
  output logic              curRspVar,
  output logic              argLast,
  output logic              rspLast,
  output logic              rspNextZero,
  output logic              rspTargetZero,
  output logic [7:0]        outData,
  output logic              lenErr
);

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] rspTarget;
  logic [CNT_W-1:0] rspNext;
  logic [CNT_W-1:0] argFixed;
  logic [CNT_W-1:0] argLenClamped;
  logic             argLenOver;
  logic             rspLenOver;
  dirShape_t        inArg;
  dirShape_t        curRsp;
  logic [7:0]       cmdBuf [BUF_DEPTH];
  logic [7:0]       rspBuf [BUF_DEPTH];

  function automatic logic [CNT_W-1:0] clampCnt(input logic [7:0] v);
    if (int'(v) > BUF_DEPTH) return CNT_W'(BUF_DEPTH);
    return CNT_W'(v);
  endfunction

  assign inArg         = argShape(inData);
  assign curRsp        = rspShape(opcode);
  assign inArgVar      = inArg.isVar;
  assign inArgZero     = (inArg.cnt == 8'd0);
  assign lenByteZero   = (inData == 8'd0);
  assign curRspVar     = curRsp.isVar;
  assign argFixed      = clampCnt(inArg.cnt);
  assign argLenClamped = clampCnt(inData);
  assign argLenOver    = int'(inData) > BUF_DEPTH;
  assign rspLenOver    = curRsp.isVar && (int'(hndRspLen) > BUF_DEPTH);
  assign rspNext       = curRsp.isVar ? clampCnt(hndRspLen) : clampCnt(curRsp.cnt);
  assign rspNextZero   = (rspNext == '0);
  assign rspTargetZero = (rspTarget == '0);
  assign argLast       = (pos == argTarget - CNT_W'(1));
  assign rspLast       = (pos == rspTarget - CNT_W'(1));

  // position counter shared by argument capture and response streaming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (stb.clearPos || stb.takeOp || stb.takeRspLen) begin
      pos <= '0;
    end else if (stb.storeArg || stb.sendByte) begin
      pos <= pos + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode    <= '0;
      argTarget <= '0;
      rspTarget <= '0;
    end else begin
      if (stb.takeOp) begin
        opcode    <= inData;
        argTarget <= argFixed;
      end else if (stb.takeArgLen) begin
        argTarget <= argLenClamped;
      end
      if (stb.takeRspLen) rspTarget <= rspNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenErr <= 1'b0;
    end else if ((stb.takeArgLen && argLenOver) || (stb.takeRspLen && rspLenOver)) begin
      lenErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeArg) cmdBuf[pos[ADDR_W-1:0]] <= inData;
  end

  always_ff @(posedge clk) begin
    if (hndRspWe) rspBuf[hndRspAddr] <= hndRspData;
  end

  assign hndArgData = cmdBuf[hndArgAddr];
  assign outData    = stb.selLen ? 8'(rspTarget) : rspBuf[pos[ADDR_W-1:0]];

endmodule

// File: rtl/cmd_framer_ctrl.sv
module cmd_framer_ctrl
  import cmd_framer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      abort,
  input  logic      inValid,
  input  logic      outReady,
  input  logic      hndDone,
  input  logic      inArgVar,
  input  logic      inArgZero,
  input  logic      lenByteZero,
  input  logic      curRspVar,
  input  logic      argLast,
  input  logic      rspLast,
  input  logic      rspNextZero,
  input  logic      rspTargetZero,
  output dpStrobe_t stb,
  output logic      inReady,
  output logic      outValid,
  output logic      hndReq
);

  protoState_t st, nxtSt;
  phase_t      ph, nxtPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
      ph <= PH_LEN;
    end else begin
      st <= nxtSt;
      ph <= nxtPh;
    end
  end

  assign inReady  = (st == ST_IDLE) || (st == ST_RECV);
  assign outValid = (st == ST_RESP) && (ph != PH_WAIT);
  assign hndReq   = (st == ST_RESP) && (ph == PH_WAIT);

  always_comb begin
    stb        = '0;
    stb.selLen = (ph == PH_LEN);
    nxtSt      = st;
    nxtPh      = ph;
    if (abort) begin
      stb.clearPos = 1'b1;
      nxtSt        = ST_IDLE;
      nxtPh        = PH_LEN;
    end else begin
      case (st)
        ST_IDLE: begin
          if (inValid) begin
            stb.takeOp = 1'b1;
            if (inArgVar) begin
              nxtSt = ST_RECV; nxtPh = PH_LEN;
            end else if (inArgZero) begin
              nxtSt = ST_RESP; nxtPh = PH_WAIT;
            end else begin
              nxtSt = ST_RECV; nxtPh = PH_DATA;
            end
          end
        end
        ST_RECV: begin
          if (inValid) begin
            if (ph == PH_LEN) begin
              stb.takeArgLen = 1'b1;
              if (lenByteZero) begin
                nxtSt = ST_RESP; nxtPh = PH_WAIT;
              end else begin
                nxtPh = PH_DATA;
              end
            end else begin
              stb.storeArg = 1'b1;
              if (argLast) begin
                nxtSt = ST_RESP; nxtPh = PH_WAIT;
              end
            end
          end
        end
        ST_RESP: begin
          case (ph)
            PH_WAIT: begin
              if (hndDone) begin
                stb.takeRspLen = 1'b1;
                if (curRspVar) begin
                  nxtPh = PH_LEN;
                end else if (rspNextZero) begin
                  nxtSt = ST_IDLE; nxtPh = PH_LEN;
                end else begin
                  nxtPh = PH_DATA;
                end
              end
            end
            PH_LEN: begin
              if (outReady) begin
                if (rspTargetZero) begin
                  nxtSt = ST_IDLE;
                end else begin
                  nxtPh = PH_DATA;
                end
              end
            end
            default: begin
              if (outReady) begin
                stb.sendByte = 1'b1;
                if (rspLast) begin
                  stb.clearPos = 1'b1;
                  nxtSt        = ST_IDLE;
                  nxtPh        = PH_LEN;
                end
              end
            end
          endcase
        end
        default: begin
          nxtSt = ST_IDLE;
          nxtPh = PH_LEN;
        end
      endcase
    end
  end

endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import cmd_framer_pkg::*;
#(
  parameter int BUF_DEPTH = 128,
  parameter int CNT_W     = $clog2(BUF_DEPTH + 1),
  parameter int ADDR_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abort,
  input  logic              inValid,
  input  logic [7:0]        inData,
  output logic              inReady,
  output logic              outValid,
  output logic [7:0]        outData,
  input  logic              outReady,
  output logic              hndReq,
  output logic [7:0]        hndOpcode,
  output logic [CNT_W-1:0]  hndArgCount,
  input  logic [ADDR_W-1:0] hndArgAddr,
  output logic [7:0]        hndArgData,
  input  logic              hndRspWe,
  input  logic [ADDR_W-1:0] hndRspAddr,
  input  logic [7:0]        hndRspData,
  input  logic [7:0]        hndRspLen,
  input  logic              hndDone,
  output logic              lenErr
);

  dpStrobe_t stb;
  logic inArgVar, inArgZero, lenByteZero, curRspVar;
  logic argLast, rspLast, rspNextZero, rspTargetZero;

  cmd_framer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .abort(abort),
    .inValid(inValid), .outReady(outReady), .hndDone(hndDone),
    .inArgVar(inArgVar), .inArgZero(inArgZero), .lenByteZero(lenByteZero),
    .curRspVar(curRspVar), .argLast(argLast), .rspLast(rspLast),
    .rspNextZero(rspNextZero), .rspTargetZero(rspTargetZero),
    .stb(stb), .inReady(inReady), .outValid(outValid), .hndReq(hndReq)
  );

  cmd_framer_dp #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .hndArgAddr(hndArgAddr), .hndArgData(hndArgData),
    .hndRspWe(hndRspWe), .hndRspAddr(hndRspAddr), .hndRspData(hndRspData),
    .hndRspLen(hndRspLen),
    .opcode(hndOpcode), .argTarget(hndArgCount),
    .inArgVar(inArgVar), .inArgZero(inArgZero), .lenByteZero(lenByteZero),
    .curRspVar(curRspVar), .argLast(argLast), .rspLast(rspLast),
    .rspNextZero(rspNextZero), .rspTargetZero(rspTargetZero),
    .outData(outData), .lenErr(lenErr)
  );

endmodule

// File: rtl/cmd_framer_chk.sv
module cmd_framer_chk #(
  parameter int BUF_DEPTH = 128,
  parameter int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             abort,
  input logic             inReady,
  input logic             outValid,
  input logic [7:0]       outData,
  input logic             outReady,
  input logic             hndReq,
  input logic [7:0]       hndOpcode,
  input logic [CNT_W-1:0] hndArgCount,
  input logic             hndDone,
  input logic             lenErr
);

  p_req_blocks_input_r2: assert property (@(posedge clk) disable iff (!rstN)
    hndReq |-> !inReady);

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hndReq && !hndDone && !abort) |=> (hndReq && $stable(hndOpcode)));

  p_count_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    hndReq |-> (int'(hndArgCount) <= BUF_DEPTH));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |=> lenErr);

  p_out_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (!inReady && !hndReq));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !abort) |=> (outValid && $stable(outData)));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (inReady && !outValid && !hndReq));

endmodule

bind cmd_framer cmd_framer_chk #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .abort(abort), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady),
  .hndReq(hndReq), .hndOpcode(hndOpcode), .hndArgCount(hndArgCount),
  .hndDone(hndDone), .lenErr(lenErr)
);

// File: tb/cmd_framer_bench.sv
`timescale 1ns/1ps
module cmd_framer_bench;
  localparam int DEPTH  = 32;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abort = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, outValid, hndReq, lenErr;
  logic [7:0] outData, hndOpcode, hndArgData;
  logic outReady = 1'b0;
  logic [CNT_W-1:0] hndArgCount;
  logic [ADDR_W-1:0] hndArgAddr = '0;
  logic hndRspWe = 1'b0;
  logic [ADDR_W-1:0] hndRspAddr = '0;
  logic [7:0] hndRspData = '0;
  logic [7:0] hndRspLen = '0;
  logic hndDone = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_framer #(.BUF_DEPTH(DEPTH)) u_cmd_framer (
    .clk(clk), .rstN(rstN), .abort(abort),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .hndReq(hndReq), .hndOpcode(hndOpcode), .hndArgCount(hndArgCount),
    .hndArgAddr(hndArgAddr), .hndArgData(hndArgData),
    .hndRspWe(hndRspWe), .hndRspAddr(hndRspAddr), .hndRspData(hndRspData),
    .hndRspLen(hndRspLen), .hndDone(hndDone), .lenErr(lenErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side opcode shapes from R11: -1 marks a length-prefixed direction
  function automatic void shapeOf(input logic [7:0] op, output int a, output int r);
    a = -1;
    r = op[3] ? -1 : 0;
    case (op)
      8'h10, 8'h11, 8'h70: begin a = 1;  r = 0;  end
      8'h20:               begin a = -1; r = 0;  end
      8'h21:               begin a = 0;  r = 0;  end
      8'h30:               begin a = 4;  r = 0;  end
      8'h31:               begin a = 20; r = 0;  end
      8'h38:               begin a = 0;  r = 4;  end
      8'h39:               begin a = 0;  r = 20; end
      8'h48:               begin a = 0;  r = 1;  end
      8'h78:               begin a = 0;  r = -1; end
      default: ;
    endcase
  endfunction

  function automatic int clampD(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  task automatic sendByte(input logic [7:0] b, input string req);
    inValid = 1'b1;
    inData  = b;
    chk(inReady === 1'b1, req, int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // full transaction; lenField is used for variable args, rspLen for variable responses
  task automatic runCmd(input logic [7:0] op, input int lenField, input int rspLen,
                        input int stall, input string req);
    int a, r, nArg, nRsp;
    logic [7:0] expQ[$];
    logic [7:0] gotQ[$];
    shapeOf(op, a, r);
    sendByte(op, req);
    if (a < 0) begin
      sendByte(8'(lenField), req);
      nArg = clampD(lenField);
    end else begin
      nArg = a;
    end
    for (int i = 0; i < nArg; i++) sendByte(8'(op + 8'(i * 3) + 8'd1), req);
    // handler request must be up in exactly this cycle
    chk(hndReq === 1'b1, {req, " hndReq"}, int'(hndReq), 1);
    chk(inReady === 1'b0, {req, " inReady during request"}, int'(inReady), 0);
    chk(hndOpcode === op, {req, " opcode"}, int'(hndOpcode), int'(op));
    chk(int'(hndArgCount) == nArg, {req, " arg count"}, int'(hndArgCount), nArg);
    for (int i = 0; i < nArg; i++) begin
      hndArgAddr = ADDR_W'(i);
      #1;
      chk(hndArgData === 8'(op + 8'(i * 3) + 8'd1), {req, " arg byte"},
          int'(hndArgData), int'(8'(op + 8'(i * 3) + 8'd1)));
    end
    nRsp = (r < 0) ? clampD(rspLen) : r;
    if (r < 0) expQ.push_back(8'(nRsp));
    for (int i = 0; i < nRsp; i++) begin
      @(negedge clk);
      hndRspWe   = 1'b1;
      hndRspAddr = ADDR_W'(i);
      hndRspData = 8'(8'hA5 ^ 8'(i * 5) ^ op);
      expQ.push_back(8'(8'hA5 ^ 8'(i * 5) ^ op));
    end
    @(negedge clk);
    hndRspWe  = 1'b0;
    hndDone   = 1'b1;
    hndRspLen = 8'(rspLen);
    @(negedge clk);
    hndDone = 1'b0;
    if (expQ.size() == 0) begin
      chk(inReady === 1'b1, {req, " idle after empty response"}, int'(inReady), 1);
      chk(outValid === 1'b0, {req, " no output"}, int'(outValid), 0);
    end else begin
      for (int s = 0; s < stall; s++) begin
        chk(outValid === 1'b1 && outData === expQ[0], {req, " stalled byte"},
            int'(outData), int'(expQ[0]));
        @(negedge clk);
      end
      outReady = 1'b1;
      for (int g = 0; g < 2 * DEPTH + 4 && outValid === 1'b1; g++) begin
        gotQ.push_back(outData);
        @(negedge clk);
      end
      outReady = 1'b0;
      chk(gotQ.size() == expQ.size(), {req, " response length"}, gotQ.size(), expQ.size());
      for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
        chk(gotQ[i] === expQ[i], {req, " response byte"}, int'(gotQ[i]), int'(expQ[i]));
      chk(inReady === 1'b1, {req, " idle after response R9"}, int'(inReady), 1);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(inReady === 1'b1, "R1 inReady", int'(inReady), 1);
    chk(outValid === 1'b0, "R1 outValid", int'(outValid), 0);
    chk(hndReq === 1'b0, "R1 hndReq", int'(hndReq), 0);
    chk(lenErr === 1'b0, "R1 lenErr", int'(lenErr), 0);
    rstN = 1'b1;
    @(negedge clk);

    runCmd(8'h30, 0, 0, 0, "R2 fixed 4 args");
    runCmd(8'h70, 0, 0, 0, "R2 fixed 1 arg");
    runCmd(8'h38, 0, 0, 0, "R3 zero args, R6 fixed 4 rsp");
    runCmd(8'h31, 0, 0, 0, "R11 20 args");
    runCmd(8'h39, 0, 0, 3, "R6 20 rsp with stall");
    runCmd(8'h20, 5, 0, 0, "R4 variable args");
    runCmd(8'h20, 0, 0, 0, "R4 zero length");
    runCmd(8'h78, 0, 3, 0, "R7 variable rsp");
    runCmd(8'h78, 0, 0, 0, "R7 zero length rsp");
    runCmd(8'h21, 0, 0, 0, "R8 empty both ways");
    runCmd(8'h2C, 2, 2, 0, "R11 default var/var");
    runCmd(8'h48, 0, 0, 0, "R9 back to back");
    chk(lenErr === 1'b0, "R5 no error yet", int'(lenErr), 0);

    runCmd(8'h20, 40, 0, 0, "R5 arg length clamp");
    chk(lenErr === 1'b1, "R5 error raised", int'(lenErr), 1);
    runCmd(8'h78, 0, 50, 0, "R5 rsp length clamp");

    // R10 abort during argument collection
    sendByte(8'h31, "R10");
    for (int i = 0; i < 5; i++) sendByte(8'(i), "R10");
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(inReady === 1'b1 && hndReq === 1'b0, "R10 abort mid-args", int'(hndReq), 0);
    runCmd(8'h30, 0, 0, 0, "R10 after abort");

    // R10 abort while handler pending
    sendByte(8'h38, "R10");
    chk(hndReq === 1'b1, "R10 pending", int'(hndReq), 1);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(hndReq === 1'b0 && inReady === 1'b1, "R10 abort pending", int'(hndReq), 0);

    // R10 abort during response stream
    sendByte(8'h39, "R10");
    hndDone = 1'b1;
    @(negedge clk);
    hndDone = 1'b0;
    outReady = 1'b1;
    repeat (2) @(negedge clk);
    outReady = 1'b0;
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(outValid === 1'b0 && inReady === 1'b1, "R10 abort mid-response",
        int'(outValid), 0);
    runCmd(8'h38, 0, 0, 0, "R10 R9 restart from address 0");
    chk(lenErr === 1'b1, "R5 sticky through abort", int'(lenErr), 1);

    repeat (2) @(negedge clk);
    finish();
  end
endmodule